// File: doc/BRIEF.md
# Floating-point control and status register with aliased views

This block holds the single 32-bit control/status word of a floating-point unit. The word carries a two-bit rounding mode, a flush-to-zero bit, five sticky exception flags, five trap enables, six cause bits and eight condition codes. Three agents update it. Software reads and writes it through a register port that decodes a five-bit view number. Arithmetic units post the exception outcome of each operation on a status port. Compare units set one condition code at a time on a condition-code port.

The register port offers the full word (view 31) and three narrower views. View 25 carries the condition codes only. View 26 carries the cause and flag fields. View 28 carries the enables, the rounding mode and the flush-to-zero bit. All three narrower views are repacked aliases of the one physical word. The block requests a floating-point trap when a write or a status post leaves an enabled cause pending, or leaves the unimplemented cause set.

The status and condition-code ports are plain strobes that never stall, so neither port has back-pressure. An event that is presented is taken in the same cycle. When several sources act in one cycle they compose in a fixed order: status post first, then condition-code set, then register write.

Top module: `fcsr_unit`

## Requirements
- R1: Reset (synchronous, active high) clears the whole word to zero. After reset every view reads zero and `fpe_req` is low.
- R2: The word layout is: rounding mode in bits 1:0, flags in 6:2, enables in 11:7, cause in 17:12, condition code 0 in bit 23, flush-to-zero in bit 24, condition codes 1 to 7 in bits 31:25, and bits 22:18 reserved. Within the flag, enable and cause fields, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. Cause bit 5 (word bit 17) is unimplemented operation. A read of view 25 returns code 0 in bit 0, codes 1 to 7 in bits 7:1, and zero above.
- R3: A write to view 25 places data bit 0 in code 0 and data bits 7:1 in codes 1 to 7. Every other bit of the word is unchanged.
- R4: View 26 reads the word masked to bits 17:12 and 6:2. A write to view 26 replaces exactly those bits from the same data positions.
- R5: A read of view 28 returns word bits 11:7 and 1:0 in place, with the flush-to-zero bit moved to bit 2. All other bits read zero.
- R6: A write to view 28 keeps the condition codes, cause and flags. It replaces the enables and rounding mode from data bits 11:7 and 1:0, and the flush-to-zero bit from data bit 2.
- R7: View 31 reads the full word with bits 22:18 forced to zero. A write to view 31 stores the data with bits 22:18 cleared.
- R8: One cycle after a write to view 26, 28 or 31, `fpe_req` pulses high for one cycle if, in the updated word, (cause bits 4:0 AND enables) is nonzero or cause bit 5 is set. A write to view 25 never raises `fpe_req`.
- R9: A status post loads cause bits 4:0 from `st_cause`, clears cause bit 5, and ORs `st_cause` into the sticky flags. No other agent ever clears the flags except a write to view 26 or 31.
- R10: A status post applies the same trap test as R8 to the updated word, with the same one-cycle latency.
- R11: A condition-code set writes `cc_val` into the single code selected by `cc_idx` and leaves every other bit unchanged.
- R12: When sources coincide in one cycle, the status post is applied first, then the condition-code set, then the register write. A later source overrides an earlier one on any bit they share.
- R13: View numbers other than 25, 26, 28 and 31 read zero, and writes to them leave the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register-port write strobe |
| reg_addr | input | 5 | View number for read and write |
| reg_wdata | input | 32 | Write data in the selected view's packing |
| reg_rdata | output | 32 | Combinational read of the selected view |
| st_valid | input | 1 | Operation status post strobe |
| st_cause | input | 5 | Exception outcome of the operation (invalid, divide-by-zero, overflow, underflow, inexact) |
| cc_valid | input | 1 | Condition-code set strobe |
| cc_idx | input | 3 | Condition code to set |
| cc_val | input | 1 | Value for that condition code |
| fpe_req | output | 1 | One-cycle floating-point trap request |

## Verification
An all-ones write through each view shows whether the repacking touches only its own fields. The later full-word read shows where each bit landed, so a gap left unclosed or a misplaced flush bit shows up as a wrong bit position rather than as a wrong count. Single-cause patterns are run with the matching enable both set and clear, which tells a true trap test apart from one that only looks at the cause. A lone unimplemented cause tells the unconditional path apart from the enabled one. Coincident status, condition-code and register events expose the composition order. Writes to unmapped view numbers, and condition-code sets on code 0 and code 7, probe the boundaries of the decode.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int CC_N    = 8;
  localparam int CCI_W   = $clog2(CC_N);
  localparam int FLAG_N  = 5;
  localparam int CAUSE_N = FLAG_N + 1;

  localparam int RM_LO    = 0;
  localparam int RM_W     = 2;
  localparam int FLAG_LO  = 2;
  localparam int EN_LO    = 7;
  localparam int CAUSE_LO = 12;
  localparam int RSV_LO   = 18;
  localparam int RSV_W    = 5;
  localparam int CC0_POS  = 23;
  localparam int FTZ_POS  = 24;
  localparam int CCHI_LO  = 25;
  localparam int UNIMPL_POS = CAUSE_LO + FLAG_N;

  localparam int VIEW_CC  = 25;
  localparam int VIEW_EXC = 26;
  localparam int VIEW_ENA = 28;
  localparam int VIEW_ALL = 31;
  localparam int FTZ_VIEW_POS = 2;

  function automatic logic [WORD_W-1:0] field_mask(int lo, int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lo+i] = 1'b1;
    return m;
  endfunction

  function automatic int cc_pos(int i);
    return (i == 0) ? CC0_POS : CCHI_LO + i - 1;
  endfunction

  function automatic logic [WORD_W-1:0] cc_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < CC_N; i++) m[cc_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] MASK_RM    = field_mask(RM_LO, RM_W);
  localparam logic [WORD_W-1:0] MASK_FLAG  = field_mask(FLAG_LO, FLAG_N);
  localparam logic [WORD_W-1:0] MASK_EN    = field_mask(EN_LO, FLAG_N);
  localparam logic [WORD_W-1:0] MASK_CAUSE = field_mask(CAUSE_LO, CAUSE_N);
  localparam logic [WORD_W-1:0] MASK_RSV   = field_mask(RSV_LO, RSV_W);
  localparam logic [WORD_W-1:0] MASK_CC    = cc_mask();
  localparam logic [WORD_W-1:0] MASK_EXCV  = MASK_CAUSE | MASK_FLAG;
  localparam logic [WORD_W-1:0] MASK_ENAV  = MASK_EN | MASK_RM;
  localparam logic [WORD_W-1:0] MASK_KEEP28 = MASK_CC | MASK_CAUSE | MASK_FLAG;
endpackage

// File: rtl/fcsr_event_merge.sv
module fcsr_event_merge
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              st_valid,
  input  logic [FLAG_N-1:0] st_cause,
  input  logic              cc_valid,
  input  logic [CCI_W-1:0]  cc_idx,
  input  logic              cc_val,
  output logic [WORD_W-1:0] word_o
);
  logic [CC_N-1:0] cc_hit;

  for (genvar g = 0; g < CC_N; g++) begin : g_cc_dec
    assign cc_hit[g] = cc_valid && (cc_idx == CCI_W'(g));
  end

  always_comb begin
    word_o = word_i;
    if (st_valid) begin
      word_o[CAUSE_LO +: CAUSE_N] = {{(CAUSE_N-FLAG_N){1'b0}}, st_cause};
      word_o[FLAG_LO +: FLAG_N]   = word_i[FLAG_LO +: FLAG_N] | st_cause;
    end
    for (int i = 0; i < CC_N; i++) begin
      if (cc_hit[i]) word_o[cc_pos(i)] = cc_val;
    end
  end
endmodule

// File: rtl/fcsr_view_access.sv
module fcsr_view_access
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_cur,
  input  logic [WORD_W-1:0] word_mid,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_checked
);
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_W'(VIEW_CC):
        for (int i = 0; i < CC_N; i++) reg_rdata[i] = word_cur[cc_pos(i)];
      ADDR_W'(VIEW_EXC): reg_rdata = word_cur & MASK_EXCV;
      ADDR_W'(VIEW_ENA): begin
        reg_rdata = word_cur & MASK_ENAV;
        reg_rdata[FTZ_VIEW_POS] = word_cur[FTZ_POS];
      end
      ADDR_W'(VIEW_ALL): reg_rdata = word_cur & ~MASK_RSV;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    word_o     = word_mid;
    wr_checked = 1'b0;
    if (reg_wr) begin
      unique case (reg_addr)
        ADDR_W'(VIEW_CC):
          for (int i = 0; i < CC_N; i++) word_o[cc_pos(i)] = reg_wdata[i];
        ADDR_W'(VIEW_EXC): begin
          word_o     = (word_mid & ~MASK_EXCV) | (reg_wdata & MASK_EXCV);
          wr_checked = 1'b1;
        end
        ADDR_W'(VIEW_ENA): begin
          word_o          = (word_mid & MASK_KEEP28) | (reg_wdata & MASK_ENAV);
          word_o[FTZ_POS] = reg_wdata[FTZ_VIEW_POS];
          wr_checked      = 1'b1;
        end
        ADDR_W'(VIEW_ALL): begin
          word_o     = reg_wdata & ~MASK_RSV;
          wr_checked = 1'b1;
        end
        default: word_o = word_mid;
      endcase
    end
  end
endmodule

// File: rtl/fcsr_trap_eval.sv
module fcsr_trap_eval
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              check_en,
  output logic              trap
);
  logic enabled_hit;
  assign enabled_hit = |(word_i[CAUSE_LO +: FLAG_N] & word_i[EN_LO +: FLAG_N]);
  assign trap = check_en && (enabled_hit || word_i[UNIMPL_POS]);
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              st_valid,
  input  logic [FLAG_N-1:0] st_cause,
  input  logic              cc_valid,
  input  logic [CCI_W-1:0]  cc_idx,
  input  logic              cc_val,
  output logic              fpe_req
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_mid;
  logic [WORD_W-1:0] word_d;
  logic              wr_checked;
  logic              trap_d;

  fcsr_event_merge u_merge (
    .word_i   (word_q),
    .st_valid (st_valid),
    .st_cause (st_cause),
    .cc_valid (cc_valid),
    .cc_idx   (cc_idx),
    .cc_val   (cc_val),
    .word_o   (word_mid)
  );

  fcsr_view_access u_view (
    .word_cur   (word_q),
    .word_mid   (word_mid),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .word_o     (word_d),
    .wr_checked (wr_checked)
  );

  fcsr_trap_eval u_trap (
    .word_i   (word_d),
    .check_en (wr_checked | st_valid),
    .trap     (trap_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      fpe_req <= 1'b0;
    end else begin
      word_q  <= word_d;
      fpe_req <= trap_d;
    end
  end
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk
  import fcsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              st_valid,
  input logic [FLAG_N-1:0] st_cause,
  input logic              cc_valid,
  input logic              fpe_req,
  input logic [WORD_W-1:0] word_q
);
  logic checked_wr;
  logic mapped;
  assign checked_wr = reg_wr && (reg_addr == ADDR_W'(VIEW_EXC) ||
                      reg_addr == ADDR_W'(VIEW_ENA) || reg_addr == ADDR_W'(VIEW_ALL));
  assign mapped = checked_wr || reg_addr == ADDR_W'(VIEW_CC);

  // R2
  cc_view_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_addr == ADDR_W'(VIEW_CC) |-> reg_rdata[WORD_W-1:CC_N] == '0);

  // R7
  rsv_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_addr == ADDR_W'(VIEW_ALL) |-> reg_rdata[RSV_LO +: RSV_W] == '0);

  // R8
  trap_source_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_valid || checked_wr) |=> !fpe_req);

  // R9
  cause_load_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid && !reg_wr |=> word_q[CAUSE_LO +: CAUSE_N] == {1'b0, $past(st_cause)});

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (reg_addr == ADDR_W'(VIEW_EXC) || reg_addr == ADDR_W'(VIEW_ALL)))
    |=> (word_q[FLAG_LO +: FLAG_N] & $past(word_q[FLAG_LO +: FLAG_N])) ==
        $past(word_q[FLAG_LO +: FLAG_N]));

  // R11
  cc_only_chk: assert property (@(posedge clk) disable iff (rst)
    cc_valid && !st_valid && !reg_wr |=>
      (word_q & ~MASK_CC) == ($past(word_q) & ~MASK_CC));

  // R13
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && !mapped && !st_valid && !cc_valid |=> $stable(word_q));
endmodule

bind fcsr_unit fcsr_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .st_valid  (st_valid),
  .st_cause  (st_cause),
  .cc_valid  (cc_valid),
  .fpe_req   (fpe_req),
  .word_q    (word_q)
);

// File: tb/fcsr_unit_test.sv
module fcsr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        st_valid = 1'b0;
  logic [4:0]  st_cause = '0;
  logic        cc_valid = 1'b0;
  logic [2:0]  cc_idx = '0;
  logic        cc_val = 1'b0;
  logic        fpe_req;

  int tests = 0;
  int fails = 0;
  logic [31:0] m = '0;

  always #5 clk = ~clk;

  fcsr_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_valid(st_valid),
    .st_cause(st_cause), .cc_valid(cc_valid), .cc_idx(cc_idx),
    .cc_val(cc_val), .fpe_req(fpe_req)
  );

  function automatic logic [31:0] view_rd(logic [31:0] w, int a);
    logic [31:0] r;
    case (a)
      25: r = {24'b0, w[31:25], w[23]};
      26: r = w & 32'h0003_F07C;
      28: r = (w & 32'h0000_0F83) | {29'b0, w[24], 2'b0};
      31: r = w & ~32'h007C_0000;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, int a, logic [31:0] d,
                      bit sv, logic [4:0] sc, bit cv, int ci, bit cb);
    bit upd;
    bit exp_trap;
    @(negedge clk);
    reg_wr = wr; reg_addr = 5'(a); reg_wdata = d;
    st_valid = sv; st_cause = sc; cc_valid = cv; cc_idx = 3'(ci); cc_val = cb;
    #1;
    check(tag, reg_rdata, view_rd(m, a));
    @(posedge clk);
    upd = 1'b0;
    if (sv) begin
      m[17:12] = {1'b0, sc};
      m[6:2]   = m[6:2] | sc;
      upd = 1'b1;
    end
    if (cv) begin
      if (ci == 0) m[23] = cb;
      else m[24+ci] = cb;
    end
    if (wr) begin
      case (a)
        25: begin m[23] = d[0]; m[31:25] = d[7:1]; end
        26: begin m = (m & ~32'h0003_F07C) | (d & 32'h0003_F07C); upd = 1'b1; end
        28: begin
          m = (m & 32'hFE83_F07C) | (d & 32'h0000_0F83);
          m[24] = d[2];
          upd = 1'b1;
        end
        31: begin m = d & ~32'h007C_0000; upd = 1'b1; end
        default: ;
      endcase
    end
    exp_trap = upd && (((m[16:12] & m[11:7]) != 0) || m[17]);
    #1;
    check(tag, {31'b0, fpe_req}, {31'b0, exp_trap});
  endtask

  task automatic rd(string tag, int a);
    step(tag, 0, a, 32'h0, 0, 5'h0, 0, 0, 0);
  endtask

  task automatic wr(string tag, int a, logic [31:0] d);
    step(tag, 1, a, d, 0, 5'h0, 0, 0, 0);
  endtask

  task automatic post(string tag, logic [4:0] c);
    step(tag, 0, 31, 32'h0, 1, c, 0, 0, 0);
  endtask

  task automatic setcc(string tag, int i, bit v);
    step(tag, 0, 25, 32'h0, 0, 5'h0, 1, i, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: every view reads zero after reset, no trap
    rd("R1", 25); rd("R1", 26); rd("R1", 28); rd("R1", 31);

    // R2, R3: condition-code view packing and spreading
    wr("R3", 25, 32'hFFFF_FFA5);
    rd("R2", 25); rd("R3", 31); rd("R3", 26);
    wr("R3", 25, 32'h0000_0001);
    rd("R2", 25); rd("R3", 31);

    // R4: cause/flag view, all-ones includes unimplemented -> trap (R8)
    wr("R4", 26, 32'hFFFF_FFFF);
    rd("R4", 26); rd("R4", 31); rd("R4", 25);
    wr("R4", 26, 32'h0000_0000);
    rd("R4", 31);

    // R5, R6: enable view with flush bit relocation
    wr("R6", 28, 32'hFFFF_FFFB);
    rd("R5", 28); rd("R6", 31);
    wr("R6", 28, 32'h0000_0004);
    rd("R5", 28); rd("R6", 31);
    wr("R6", 26, 32'h0000_007C);
    wr("R6", 28, 32'h0000_0003);
    rd("R6", 26); rd("R5", 28);

    // R8: divide-by-zero cause with and without its enable
    wr("R8", 28, 32'h0000_0400);
    wr("R8", 26, 32'h0000_8000);
    wr("R8", 28, 32'h0000_0000);
    wr("R8", 26, 32'h0000_8000);
    wr("R8", 26, 32'h0002_0000);
    wr("R8", 28, 32'h0000_0F80);
    wr("R8", 25, 32'h0000_00FF);
    rd("R8", 31);

    // R9, R10: status posts
    wr("R9", 31, 32'h0000_0000);
    wr("R10", 28, 32'h0000_0200);
    post("R10", 5'b00100);
    rd("R9", 26);
    post("R9", 5'b00001);
    rd("R9", 26);
    post("R9", 5'b00000);
    rd("R9", 26);
    wr("R9", 26, 32'h0002_0000);
    post("R9", 5'b10000);
    rd("R9", 31);

    // R11: individual condition codes, including both ends
    wr("R11", 31, 32'h0000_0000);
    setcc("R11", 0, 1); rd("R11", 31);
    setcc("R11", 7, 1); rd("R11", 25);
    setcc("R11", 3, 1); setcc("R11", 3, 0); rd("R11", 25);
    setcc("R11", 0, 0); rd("R11", 31);

    // R12: coincident sources
    step("R12", 1, 26, 32'h0000_1000, 1, 5'b01000, 1, 2, 1);
    rd("R12", 31);
    step("R12", 1, 25, 32'h0000_0000, 1, 5'b00010, 1, 5, 1);
    rd("R12", 31);
    step("R12", 1, 28, 32'h0000_0F80, 1, 5'b00001, 0, 0, 0);
    rd("R12", 31);

    // R13: unmapped views
    wr("R13", 5, 32'hFFFF_FFFF);
    wr("R13", 30, 32'hFFFF_FFFF);
    rd("R13", 0); rd("R13", 27); rd("R13", 31);

    // R7: reserved bits
    wr("R7", 31, 32'hFFFF_FFFF);
    rd("R7", 31); rd("R7", 25); rd("R7", 28);
    wr("R7", 31, 32'h007C_0000);
    rd("R7", 31);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule